// File: doc/BRIEF.md
# Index-Decoded Output Line Latch Bank

This block holds the output levels of a small 4-bit controller: ten data lines, one remote-control line and four auxiliary lines. A clear strobe drives the lines selected by a 4-bit index to 0. A set strobe drives the same selection to 1. Between strobes every line keeps its level.

The index map is not uniform. Low codes pick one data line. Code 8 picks the remote line. Code 9 picks every data line. Codes Ah to Dh pick one auxiliary line. Code Eh picks every auxiliary line. Code Fh picks every data line and every auxiliary line, but not the remote line.

The instruction decoder drives `idx_i` together with one strobe. The outputs go straight to the port drivers. There is no data stream at this edge, so every pin is a plain control or level signal.

Top module: `obl_port_latch`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, every output line is 1 after that edge.
- R2: A clear with index 0 to 7 drives only data line `data_o[idx]` to 0. All other lines hold.
- R3: A clear with index 8 drives only `remote_o` to 0. The remote line changes for no other clear index.
- R4: A clear with index 9 drives all of `data_o[9:0]` to 0. The remote and auxiliary lines hold.
- R5: A clear with index Ah to Dh drives only `aux_o[idx-Ah]` to 0, so Ah selects bit 0 and Dh selects bit 3.
- R6: A clear with index Eh drives all of `aux_o[3:0]` to 0. The data and remote lines hold.
- R7: A clear with index Fh drives all data lines and all auxiliary lines to 0. The remote line holds.
- R8: A set strobe uses the same index map and drives the selected line or group to 1.
- R9: When both strobes are high in one cycle, only the clear is carried out. The set is ignored entirely.
- R10: With neither strobe high, every line holds. Data lines 8 and 9 change only through index 9 or Fh.
- R11: Strobes are sampled at the rising edge, and the outputs change at that same edge and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high; drives all lines to 1 |
| idx_i | input | 4 | Index that selects a line or a group |
| clr_stb_i | input | 1 | Drive the selected lines to 0 |
| set_stb_i | input | 1 | Drive the selected lines to 1 |
| data_o | output | 10 | Latched data lines 0..9 |
| remote_o | output | 1 | Latched remote-control line |
| aux_o | output | 4 | Latched auxiliary lines 0..3 |

## Verification
The bench builds the block with the default package values: ten data lines, four auxiliary lines and a 4-bit index. With these values all sixteen index codes are legal and reachable, so the bench sweeps every code under clear, under set and under both strobes together. Random mixes of codes and strobes follow. These runs reach the paths that only groups can take, such as data lines 8 and 9, and the remote line, which code Fh leaves untouched.

// File: rtl/obl_pkg.sv
package obl_pkg;
  localparam int unsigned IDX_W         = 4;
  localparam int unsigned DATA_N        = 10;
  localparam int unsigned AUX_N         = 4;
  localparam int unsigned SINGLE_DATA_N = 8;
  localparam int unsigned LINES_N       = DATA_N + 1 + AUX_N;

  localparam logic [IDX_W-1:0] IDX_REMOTE   = 4'h8;
  localparam logic [IDX_W-1:0] IDX_ALL_DATA = 4'h9;
  localparam logic [IDX_W-1:0] IDX_AUX_BASE = 4'hA;
  localparam logic [IDX_W-1:0] IDX_ALL_AUX  = 4'hE;
  localparam logic [IDX_W-1:0] IDX_EVERY    = 4'hF;

  typedef struct packed {
    logic [DATA_N-1:0] data;
    logic              remote;
    logic [AUX_N-1:0]  aux;
  } line_vec_t;
endpackage

// File: rtl/obl_index_decode.sv
module obl_index_decode
  import obl_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output line_vec_t        hit
);
  always_comb begin
    hit = '0;
    for (int k = 0; k < int'(SINGLE_DATA_N); k++) begin
      if (idx == IDX_W'(k)) hit.data[k] = 1'b1;
    end
    for (int k = 0; k < int'(AUX_N); k++) begin
      if (idx == IDX_AUX_BASE + IDX_W'(k)) hit.aux[k] = 1'b1;
    end
    if (idx == IDX_REMOTE) hit.remote = 1'b1;
    if (idx == IDX_ALL_DATA || idx == IDX_EVERY) hit.data = '1;
    if (idx == IDX_ALL_AUX  || idx == IDX_EVERY) hit.aux  = '1;
  end
endmodule

// File: rtl/obl_op_arbiter.sv
module obl_op_arbiter
  import obl_pkg::*;
(
  input  logic               clr_stb,
  input  logic               set_stb,
  input  line_vec_t          hit,
  output logic [LINES_N-1:0] clr_mask,
  output logic [LINES_N-1:0] set_mask
);
  // Clear wins: a set in the same cycle is dropped as a whole.
  always_comb begin
    clr_mask = clr_stb ? LINES_N'(hit) : '0;
    set_mask = (set_stb && !clr_stb) ? LINES_N'(hit) : '0;
  end
endmodule

// File: rtl/obl_latch_bank.sv
module obl_latch_bank #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < int'(W); b++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)              q[b] <= 1'b1;
      else if (clr_mask[b]) q[b] <= 1'b0;
      else if (set_mask[b]) q[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/obl_port_latch.sv
module obl_port_latch
  import obl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              clr_stb_i,
  input  logic              set_stb_i,
  output logic [DATA_N-1:0] data_o,
  output logic              remote_o,
  output logic [AUX_N-1:0]  aux_o
);
  line_vec_t          hit;
  logic [LINES_N-1:0] clr_mask;
  logic [LINES_N-1:0] set_mask;
  logic [LINES_N-1:0] q_flat;
  line_vec_t          q;

  obl_index_decode i_dec (
    .idx (idx_i),
    .hit (hit)
  );

  obl_op_arbiter i_arb (
    .clr_stb  (clr_stb_i),
    .set_stb  (set_stb_i),
    .hit      (hit),
    .clr_mask (clr_mask),
    .set_mask (set_mask)
  );

  obl_latch_bank #(.W(LINES_N)) i_bank (
    .clk      (clk),
    .rst      (rst),
    .clr_mask (clr_mask),
    .set_mask (set_mask),
    .q        (q_flat)
  );

  assign q        = line_vec_t'(q_flat);
  assign data_o   = q.data;
  assign remote_o = q.remote;
  assign aux_o    = q.aux;
endmodule

// File: rtl/obl_port_latch_chk.sv
module obl_port_latch_chk
  import obl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  idx_i,
  input logic              clr_stb_i,
  input logic              set_stb_i,
  input logic [DATA_N-1:0] data_o,
  input logic              remote_o,
  input logic [AUX_N-1:0]  aux_o
);
  a_r1_reset_high: assert property (@(posedge clk)
    rst |=> (&data_o && remote_o && &aux_o));

  a_r2_single_data: assert property (@(posedge clk) disable iff (rst)
    (clr_stb_i && idx_i < IDX_W'(SINGLE_DATA_N)) |=> !data_o[$past(idx_i[2:0])]);

  a_r3_remote_only_8: assert property (@(posedge clk) disable iff (rst)
    (clr_stb_i && idx_i != IDX_REMOTE) |=> $stable(remote_o));

  a_r4_all_data: assert property (@(posedge clk) disable iff (rst)
    (clr_stb_i && idx_i == IDX_ALL_DATA) |=> (data_o == '0 && $stable(aux_o)));

  a_r7_every: assert property (@(posedge clk) disable iff (rst)
    (clr_stb_i && idx_i == IDX_EVERY) |=> (data_o == '0 && aux_o == '0));

  a_r8_set_every: assert property (@(posedge clk) disable iff (rst)
    (set_stb_i && !clr_stb_i && idx_i == IDX_EVERY) |=> (&data_o && &aux_o));

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_stb_i && set_stb_i && idx_i == IDX_ALL_AUX) |=> aux_o == '0);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_stb_i && !set_stb_i) |=> ($stable(data_o) && $stable(remote_o) && $stable(aux_o)));
endmodule

bind obl_port_latch obl_port_latch_chk i_chk (.*);

// File: tb/test_obl_port_latch.sv
module test_obl_port_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] idx_i = 4'h0;
  logic       clr_stb_i = 1'b0;
  logic       set_stb_i = 1'b0;
  logic [9:0] data_o;
  logic       remote_o;
  logic [3:0] aux_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  logic [9:0] m_d = '1;
  logic       m_r = 1'b1;
  logic [3:0] m_a = '1;

  always #4 clk = ~clk;

  obl_port_latch i_obl_port_latch (
    .clk(clk), .rst(rst), .idx_i(idx_i), .clr_stb_i(clr_stb_i),
    .set_stb_i(set_stb_i), .data_o(data_o), .remote_o(remote_o), .aux_o(aux_o)
  );

  function automatic bit d_hit(int j, int ix);
    return (ix < 8 && ix == j) || ix == 9 || ix == 15;
  endfunction
  function automatic bit a_hit(int j, int ix);
    return (ix == 10 + j) || ix == 14 || ix == 15;
  endfunction

  // reference model
  always @(posedge clk) begin
    logic [9:0] nd; logic nr; logic [3:0] na; bit v;
    nd = m_d; nr = m_r; na = m_a;
    if (rst) begin
      nd = '1; nr = 1'b1; na = '1;
    end else if (clr_stb_i || set_stb_i) begin
      v = !clr_stb_i;
      for (int j = 0; j < 10; j++) if (d_hit(j, int'(idx_i))) nd[j] = v;
      for (int j = 0; j < 4; j++)  if (a_hit(j, int'(idx_i))) na[j] = v;
      if (idx_i == 4'h8) nr = v;
    end
    m_d <= nd; m_r <= nr; m_a <= na;
  end

  function automatic string tag_of(bit r, bit c, bit s, logic [3:0] ix);
    if (r) return "R1";
    if (c && s) return "R9";
    if (!c && !s) return "R10";
    if (s) return "R8";
    if (ix < 8) return "R2";
    if (ix == 8) return "R3";
    if (ix == 9) return "R4";
    if (ix < 14) return "R5";
    if (ix == 14) return "R6";
    return "R7";
  endfunction

  task automatic compare(string tag);
    checks++;
    if ({data_o, remote_o, aux_o} !== {m_d, m_r, m_a}) begin
      errors++;
      $display("FAIL %s actual d=%b r=%b a=%b expected d=%b r=%b a=%b",
               tag, data_o, remote_o, aux_o, m_d, m_r, m_a);
    end
  endtask

  task automatic step(bit r, bit c, bit s, logic [3:0] ix);
    @(negedge clk);
    compare(cur_tag);
    rst = r; clr_stb_i = c; set_stb_i = s; idx_i = ix;
    cur_tag = tag_of(r, c, s, ix);
    #1;
    compare("R11");  // no change before the sampling edge
  endtask

  initial begin
    step(1, 0, 0, 4'h0);
    step(1, 0, 0, 4'h0);
    step(0, 0, 0, 4'h0);
    // every single clear, restored by set of the same index
    for (int ix = 0; ix < 16; ix++) begin
      step(0, 1, 0, 4'(ix));
      step(0, 0, 0, 4'(ix));
      step(0, 0, 1, 4'(ix));
    end
    // D8/D9 untouched by single-line indices
    for (int ix = 0; ix < 8; ix++) step(0, 1, 0, 4'(ix));
    step(0, 0, 0, 4'h0);
    @(negedge clk);
    checks++;
    if (data_o[9:8] !== 2'b11) begin
      errors++;
      $display("FAIL R10 actual d98=%b expected d98=11", data_o[9:8]);
    end
    step(0, 0, 1, 4'h9);
    // both strobes together
    for (int ix = 0; ix < 16; ix++) step(0, 1, 1, 4'(ix));
    step(0, 0, 1, 4'hF);
    step(0, 0, 1, 4'h8);
    // random mix, with a mid-run reset
    for (int n = 0; n < 400; n++) begin
      step(n == 200, ($urandom % 3) == 0, ($urandom % 3) == 0, 4'($urandom));
    end
    step(0, 0, 0, 4'h0);
    step(0, 0, 0, 4'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule